// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block turns a set of 2t syndromes of a binary BCH codeword into the error-locator polynomial sigma(x) and its degree. It runs a shortened Berlekamp–Massey iteration that suits binary codes: the step index moves by two on each pass, and only the odd syndromes open a new discrepancy, because in a binary code the even syndromes are squares of the odd ones. The block sits between a syndrome generator and a root search, and it touches neither of them.

A one-cycle `start` loads the syndromes and the run-time strength t (1 to T). The solver keeps a small table of rows. Each row holds its mu, sigma coefficients, degree, discrepancy and delta = mu − degree. The solver spends one cycle on each polynomial update and one on each new discrepancy. It can leave the loop early once enough zero discrepancies have been counted. When it finishes it presents sigma_0..sigma_T and the degree, and it pulses `done` for one cycle. The field degree M and the primitive polynomial are parameters.

Top module: `bch_bm_solver`

## Requirements
- R1: After reset, `done` is 0, `sigmaOut` is all zeros and `degOut` is 0.
- R2: `start` is sampled only while the solver is idle, and it captures `tSel` and `synIn`. Syndrome S_k sits in `synIn` bits [k*M-1:(k-1)*M]. Each run raises `done` for exactly one cycle.
- R3: When the number of errors e is at most t, `sigmaOut` equals the product of (1 + alpha^p·x) over the error positions p. Coefficient k sits in bits [(k+1)*M-1:k*M]. Field elements are in polynomial basis, with bit i the coefficient of alpha^i.
- R4: When e ≤ t, `degOut` equals e.
- R5: Every coefficient of `sigmaOut` above the reported degree is zero.
- R6: A run that does not exit early raises `done` exactly 2t−1 clock edges after the edge that samples `start`. No run takes longer than that.
- R7: The solver leaves the loop when the running count of zero discrepancies reaches the threshold. The threshold is q/2+2 for odd q and q/2+1 for even q, where q = t − degree − 1. The result is then the current row. With t = 3 and all syndromes zero, `done` rises 3 edges after the sampling edge.
- R8: Syndromes S_{2t+1} to S_{2T} have no effect on the result when t < T.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| tSel | input | $clog2(T+1) | Correction strength t for this run, 1..T |
| synIn | input | 2*T*M | Syndromes S_1..S_2T, S_1 in the low bits |
| sigmaOut | output | (T+1)*M | sigma_0..sigma_T, sigma_0 in the low bits |
| degOut | output | $clog2(2*T+2) | Degree of sigma |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench sweeps every pattern of up to t errors over a 15-bit code in GF(16), for each t from 1 to 3. For each pattern it compares the locator with a product built arithmetically. A wrong choice of the earlier reference row, or a shift by the wrong mu difference, gives wrong coefficients even when the degree is right. A broken inverse or field multiply does the same. The zero-syndrome run at t = 3 exposes a threshold that is off by one, or a counter that never fires: such a design finishes at edge 5 instead of edge 3. Garbage in the unused upper syndromes exposes any discrepancy step that reads beyond S_2t.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef struct packed {
    logic init;
    logic upd;
    logic dsc;
  } bmCtl_t;

  typedef enum logic [1:0] {S_IDLE, S_UPD, S_DSC, S_FIN} bmState_t;
endpackage

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   earlyExit,
  input  logic   lastIter,
  output bmCtl_t ctl,
  output logic   done
);
  bmState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE: if (start) stateNxt = S_UPD;
      S_UPD:  stateNxt = (earlyExit || lastIter) ? S_FIN : S_DSC;
      S_DSC:  stateNxt = S_UPD;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign ctl.init = (state == S_IDLE) && start;
  assign ctl.upd  = (state == S_UPD);
  assign ctl.dsc  = (state == S_DSC);
  assign done     = (state == S_FIN);

  // R2: the result strobe lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a result only ever follows an update pass
  p_done_after_upd_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(ctl.upd));
endmodule

// File: rtl/bm_dpath.sv
module bm_dpath
  import bm_pkg::*;
#(
  parameter int M    = 4,
  parameter int T    = 3,
  parameter int POLY = 'h13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bmCtl_t                  ctl,
  input  logic [$clog2(T+1)-1:0]  tIn,
  input  logic [2*T*M-1:0]        synIn,
  output logic                    earlyExit,
  output logic                    lastIter,
  output logic [(T+1)*M-1:0]      sigmaOut,
  output logic [$clog2(2*T+2)-1:0] degOut
);
  localparam int NS  = 2 * T;
  localparam int NR  = T + 2;
  localparam int NC  = 2 * T + 1;
  localparam int IW  = $clog2(NR);
  localparam int SW  = $clog2(4 * T + 4) + 2;
  localparam int DOW = $clog2(2 * T + 2);
  localparam logic [M-1:0] RED = POLY[M-1:0];

  function automatic logic [M-1:0] gfMul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int n = 0; n < M; n++) begin
      if (b[n]) acc = acc ^ sh;
      sh = sh[M-1] ? ((sh << 1) ^ RED) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] gfInv(input logic [M-1:0] a);
    logic [M-1:0] acc, sq;
    acc = {{(M-1){1'b0}}, 1'b1};
    sq  = a;
    for (int n = 1; n < M; n++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc;
  endfunction

  logic [M-1:0]          syn    [1:NS];
  logic [$clog2(T+1)-1:0] tReg;
  logic [IW-1:0]         iIdx, nxt, ro;
  logic signed [SW-1:0]  zCnt, thr, qv, best, diffV, newDeg, degRo;
  logic signed [SW-1:0]  rowMu  [NR];
  logic signed [SW-1:0]  rowDeg [NR];
  logic signed [SW-1:0]  rowDel [NR];
  logic [M-1:0]          rowD   [NR];
  logic [M-1:0]          rowSig [NR][NC];
  logic [M-1:0]          newSig [NC];
  logic [M-1:0]          resSig [T+1];
  logic signed [SW-1:0]  resDeg;
  logic [M-1:0]          dI, factor, dNew;
  logic                  dZero;

  assign nxt      = IW'(int'(iIdx) + 1);
  assign dI       = rowD[iIdx];
  assign dZero    = (dI == '0);
  assign lastIter = (int'(iIdx) == int'(tReg));

  // Early-exit threshold from the current degree
  always_comb begin
    qv  = SW'(int'(tReg) - int'(rowDeg[iIdx]) - 1);
    thr = qv[0] ? SW'(int'(qv) / 2 + 2) : SW'(int'(qv) / 2 + 1);
    earlyExit = ctl.upd && dZero && (zCnt + SW'(1) == thr);
  end

  // Reference row: nonzero discrepancy, strictly largest delta, first wins
  always_comb begin
    ro   = '0;
    best = -SW'(1);
    for (int j = 0; j < NR; j++) begin
      if (j < int'(iIdx) && rowD[j] != '0 && rowDel[j] > best) begin
        best = rowDel[j];
        ro   = IW'(j);
      end
    end
    diffV  = rowMu[iIdx] - rowMu[ro];
    degRo  = rowDeg[ro] + diffV;
    factor = gfMul(dI, gfInv(rowD[ro]));
    newDeg = dZero ? rowDeg[iIdx] : ((rowDeg[iIdx] > degRo) ? rowDeg[iIdx] : degRo);
    for (int k = 0; k < NC; k++) begin
      newSig[k] = rowSig[iIdx][k];
      if (!dZero) begin
        for (int s = 0; s < NC; s++) begin
          if (s + int'(diffV) == k) newSig[k] = newSig[k] ^ gfMul(factor, rowSig[ro][s]);
        end
      end
    end
  end

  // Next discrepancy from the odd syndrome 2i+1 and the fresh row
  always_comb begin
    dNew = '0;
    for (int n = 1; n <= NS; n++) begin
      if (n == 2 * int'(iIdx) + 1) dNew = dNew ^ syn[n];
      for (int k = 1; k < NC; k++) begin
        if (k <= int'(rowDeg[nxt]) && n + k == 2 * int'(iIdx) + 1)
          dNew = dNew ^ gfMul(rowSig[nxt][k], syn[n]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tReg <= '0;
      iIdx <= '0;
      zCnt <= '0;
      resDeg <= '0;
      for (int n = 1; n <= NS; n++) syn[n] <= '0;
      for (int k = 0; k <= T; k++) resSig[k] <= '0;
      for (int r = 0; r < NR; r++) begin
        rowMu[r] <= '0; rowDeg[r] <= '0; rowDel[r] <= '0; rowD[r] <= '0;
        for (int k = 0; k < NC; k++) rowSig[r][k] <= '0;
      end
    end else if (ctl.init) begin
      tReg <= tIn;
      iIdx <= IW'(1);
      zCnt <= '0;
      for (int n = 1; n <= NS; n++) syn[n] <= synIn[(n-1)*M +: M];
      for (int r = 0; r < 2; r++) begin
        rowMu[r]  <= SW'(r - 1);
        rowDeg[r] <= '0;
        rowDel[r] <= SW'(r - 1);
        for (int k = 0; k < NC; k++) rowSig[r][k] <= (k == 0) ? M'(1) : '0;
      end
      rowD[0] <= M'(1);
      rowD[1] <= synIn[M-1:0];
    end else if (ctl.upd) begin
      if (dZero) zCnt <= zCnt + SW'(1);
      if (!earlyExit) begin
        rowMu[nxt]  <= SW'(2 * int'(iIdx));
        rowDeg[nxt] <= newDeg;
        rowDel[nxt] <= SW'(2 * int'(iIdx)) - newDeg;
        for (int k = 0; k < NC; k++) rowSig[nxt][k] <= newSig[k];
      end
      resDeg <= earlyExit ? rowDeg[iIdx] : newDeg;
      for (int k = 0; k <= T; k++)
        resSig[k] <= (k > int'(earlyExit ? rowDeg[iIdx] : newDeg)) ? '0 :
                     (earlyExit ? rowSig[iIdx][k] : newSig[k]);
    end else if (ctl.dsc) begin
      rowD[nxt] <= dNew;
      iIdx      <= nxt;
    end
  end

  always_comb begin
    for (int k = 0; k <= T; k++) sigmaOut[k*M +: M] = resSig[k];
    degOut = DOW'(resDeg);
  end

  // R3: the divisor picked for the update is never zero
  p_ro_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.upd && !dZero) |-> (rowD[ro] != '0));

  // R7: zero-discrepancy count never passes t
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(zCnt) <= int'(tReg));

  // R6: the loop index stays within 1..t while running
  p_iter_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.upd || ctl.dsc) |-> (iIdx != '0 && int'(iIdx) <= int'(tReg)));

  // R7: a zero discrepancy without exit carries the degree forward
  p_zero_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.upd && dZero && !earlyExit) |=> (rowDeg[IW'(int'(iIdx) + 1)] == $past(rowDeg[iIdx])));
endmodule

// File: rtl/bch_bm_solver.sv
module bch_bm_solver
  import bm_pkg::*;
#(
  parameter int M    = 4,
  parameter int T    = 3,
  parameter int POLY = 'h13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [$clog2(T+1)-1:0]   tSel,
  input  logic [2*T*M-1:0]         synIn,
  output logic [(T+1)*M-1:0]       sigmaOut,
  output logic [$clog2(2*T+2)-1:0] degOut,
  output logic                     done
);
  bmCtl_t ctl;
  logic   earlyExit, lastIter;

  bm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .earlyExit(earlyExit), .lastIter(lastIter),
    .ctl(ctl), .done(done)
  );

  bm_dpath #(.M(M), .T(T), .POLY(POLY)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tIn(tSel), .synIn(synIn),
    .earlyExit(earlyExit), .lastIter(lastIter),
    .sigmaOut(sigmaOut), .degOut(degOut)
  );
endmodule

// File: tb/bch_bm_solver_tb.sv
`timescale 1ns/1ps
module bch_bm_solver_tb_top;
  localparam int M = 4;
  localparam int T = 3;
  localparam int N = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] tSel = '0;
  logic [2*T*M-1:0] synIn = '0;
  logic [(T+1)*M-1:0] sigmaOut;
  logic [2:0] degOut;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [3:0] pw [N];

  always #4 clk = ~clk;

  bch_bm_solver #(.M(M), .T(T), .POLY('h13)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .tSel(tSel), .synIn(synIn),
    .sigmaOut(sigmaOut), .degOut(degOut), .done(done)
  );

  function automatic logic [3:0] fmul(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
    for (int i = 7; i >= 4; i--) if (p[i]) p = p ^ (8'h13 << (i - 4));
    return p[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCase(input int t, input int e, input int a, input int b, input int c);
    int pos [3];
    logic [3:0] expSig [T+1];
    logic [3:0] s;
    int lat, expLat;
    pos[0] = a; pos[1] = b; pos[2] = c;
    for (int k = 0; k <= T; k++) expSig[k] = (k == 0) ? 4'd1 : 4'd0;
    for (int n = 0; n < e; n++)
      for (int k = T; k >= 1; k--) expSig[k] = expSig[k] ^ fmul(expSig[k-1], pw[pos[n]]);
    for (int j = 1; j <= 2*T; j++) begin
      s = '0;
      for (int n = 0; n < e; n++) s = s ^ pw[(pos[n] * j) % N];
      if (j > 2*t) s = 4'(j * 7 + 5);   // R8: junk above 2t
      synIn[(j-1)*M +: M] = s;
    end
    tSel = 2'(t);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    expLat = (t == 3 && e == 0) ? 3 : 2*t - 1;
    chk(lat == expLat, (e == 0 && t == 3) ? "R7 early exit latency" : "R6 latency", lat, expLat);
    for (int k = 0; k <= T; k++) begin
      if (k <= e) chk(sigmaOut[k*M +: M] == expSig[k], "R3 R8 sigma coefficient", sigmaOut[k*M +: M], expSig[k]);
      else        chk(sigmaOut[k*M +: M] == '0, "R5 zero above degree", sigmaOut[k*M +: M], 0);
    end
    chk(int'(degOut) == e, "R4 degree", degOut, e);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single pulse", done, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pw[0] = 4'd1;
    for (int i = 1; i < N; i++) pw[i] = fmul(pw[i-1], 4'd2);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(sigmaOut == '0, "R1 reset sigma", sigmaOut, 0);
    chk(degOut == '0, "R1 reset degree", degOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R2 idle without start", done, 0);
    for (int t = 1; t <= T; t++) begin
      runCase(t, 0, 0, 0, 0);
      for (int a = 0; a < N; a++) begin
        runCase(t, 1, a, 0, 0);
        if (t >= 2)
          for (int b = a + 1; b < N; b++) begin
            runCase(t, 2, a, b, 0);
            if (t >= 3)
              for (int c = b + 1; c < N; c++) runCase(t, 3, a, b, c);
          end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule